// File: doc/BRIEF.md
# Sequential buffer address pointer

This block produces the word address for the clocked side of a dual-port buffer memory of 8192 sixteen-bit words. Each rising clock edge can leave the 13-bit pointer where it is, step it forward by one, send it to one of two programmable buffer start addresses, or finish a two-step load from the data bus. A load captures a 12-bit value on one edge and applies it on the next.

Two end-of-buffer addresses are compared against the pointer. Each one drives an active-low flag. A flag falls when counting brings the pointer onto its end address, and it stays low until cleared. A flag is cleared by reset or by a control write that carries a zero in that flag's bit.

The start and end addresses are programmed through a small indexed register-write port. The memory array and the random-access side are outside this block.

Top module: `seq_addr_ptr`

## Requirements
- R1: While `rst` is high at a rising edge, that edge sets `ptr` to 0 and both flags high. It also sets all four start/end registers to 0 and cancels any load in progress.
- R2: With no load completing and neither start strobe low, `cnt_en_n` low at an edge advances `ptr` by one. From 8191 it goes to 0. With `cnt_en_n` high, `ptr` holds.
- R3: `ld_n` low at an edge captures `din[11:0]`. At the next edge `ptr` takes that value, with bit 12 cleared. Count enable and the start strobes have no effect on that second edge.
- R4: `strt1_n` low at an edge loads `ptr` from start register 1, and `strt2_n` low loads it from start register 2. If both are low, start register 1 wins. A start strobe must not be low while `ld_n` is low, nor in the cycle after `ld_n` was low.
- R5: On a single edge the order of precedence is reset, then a pending load, then strobe 1, then strobe 2, then the increment.
- R6: `cfg_we` high writes `cfg_data` into the register chosen by `cfg_idx`: 0 is start 1, 1 is end 1, 2 is start 2, 3 is end 2. Indices 4 to 7 change nothing. A written value is used from the following edge onward.
- R7: `eob1_n` (or `eob2_n`) goes low at the edge where an increment makes `ptr` equal to end register 1 (or 2). Reaching that address by a load or a start strobe does not lower the flag.
- R8: A low flag stays low until cleared. `ctl_we` high with `ctl_data[0]` at 0 raises `eob1_n`, and with `ctl_data[1]` at 0 raises `eob2_n`. A 1 in a bit leaves its flag alone. If a flag is set and cleared on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en_n | input | 1 | Count enable, active low |
| ld_n | input | 1 | Load request from data bus, active low |
| strt1_n | input | 1 | Jump to start address 1, active low |
| strt2_n | input | 1 | Jump to start address 2, active low |
| din | input | 12 | Load value |
| cfg_we | input | 1 | Start/end register write strobe |
| cfg_idx | input | 3 | Start/end register index |
| cfg_data | input | 13 | Start/end register write value |
| ctl_we | input | 1 | Control write strobe for flag clearing |
| ctl_data | input | 2 | Control value; a 0 bit clears its flag |
| ptr | output | 13 | Current word address |
| eob1_n | output | 1 | End-of-buffer flag 1, active low |
| eob2_n | output | 1 | End-of-buffer flag 2, active low |

## Verification
Counting, strobe jumps, flag setting, flag clearing and reset all show up at the ports right after the edge that samples them. A load needs two edges: the first captures `din` and the second moves `ptr`. A register write changes behaviour only from the edge after the write. The bench drives inputs on the falling edge and runs a behavioural model on the same rising edge as the design, using the values sampled before that edge, so the model follows these latencies. It compares `ptr` and both flags 1 ns after every rising edge, and the targeted checks sample at that same point once the stated number of edges has passed.

// File: rtl/seq_ptr_pkg.sv
package seq_ptr_pkg;
  localparam int unsigned PTR_W   = 13;
  localparam int unsigned LOAD_W  = 12;
  localparam int unsigned NUM_BUF = 2;
  localparam int unsigned IDX_W   = 3;
endpackage

// File: rtl/seq_ptr_regs.sv
module seq_ptr_regs #(
  parameter int unsigned AW    = seq_ptr_pkg::PTR_W,
  parameter int unsigned NBUF  = seq_ptr_pkg::NUM_BUF,
  parameter int unsigned IDX_W = seq_ptr_pkg::IDX_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [IDX_W-1:0]         cfg_idx,
  input  logic [AW-1:0]            cfg_data,
  output logic [NBUF-1:0][AW-1:0]  start_addr,
  output logic [NBUF-1:0][AW-1:0]  end_addr
);
  // Index layout: even slot = start of buffer b, odd slot = end of buffer b.
  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    localparam logic [IDX_W-1:0] START_IDX = IDX_W'(2 * b);
    localparam logic [IDX_W-1:0] END_IDX   = IDX_W'(2 * b + 1);

    always_ff @(posedge clk) begin
      if (rst) begin
        start_addr[b] <= '0;
        end_addr[b]   <= '0;
      end else if (cfg_we) begin
        if (cfg_idx == START_IDX) start_addr[b] <= cfg_data;
        if (cfg_idx == END_IDX)   end_addr[b]   <= cfg_data;
      end
    end
  end
endmodule

// File: rtl/seq_ptr_core.sv
module seq_ptr_core #(
  parameter int unsigned AW   = seq_ptr_pkg::PTR_W,
  parameter int unsigned LW   = seq_ptr_pkg::LOAD_W,
  parameter int unsigned NBUF = seq_ptr_pkg::NUM_BUF
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cnt_en_n,
  input  logic                     ld_n,
  input  logic [NBUF-1:0]          strt_n,
  input  logic [LW-1:0]            din,
  input  logic [NBUF-1:0][AW-1:0]  start_addr,
  output logic [AW-1:0]            ptr,
  output logic [AW-1:0]            ptr_inc,
  output logic                     inc_take,
  output logic                     ld_pend
);
  logic [LW-1:0] dreg_q;
  logic [AW-1:0] ptr_nxt;
  logic          strt_hit;

  // Selection: pending load, then lowest-numbered strobe, then increment.
  always_comb begin
    ptr_inc  = ptr + 1'b1;
    ptr_nxt  = ptr;
    inc_take = 1'b0;
    strt_hit = 1'b0;
    if (ld_pend) begin
      ptr_nxt = AW'(dreg_q);
    end else begin
      for (int b = NBUF - 1; b >= 0; b--) begin
        if (!strt_n[b]) begin
          ptr_nxt  = start_addr[b];
          strt_hit = 1'b1;
        end
      end
      if (!strt_hit && !cnt_en_n) begin
        ptr_nxt  = ptr_inc;
        inc_take = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr     <= '0;
      dreg_q  <= '0;
      ld_pend <= 1'b0;
    end else begin
      ptr     <= ptr_nxt;
      ld_pend <= !ld_n;
      if (!ld_n) dreg_q <= din;
    end
  end
endmodule

// File: rtl/seq_ptr_flag.sv
module seq_ptr_flag #(
  parameter int unsigned AW = seq_ptr_pkg::PTR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc_take,
  input  logic [AW-1:0] ptr_inc,
  input  logic [AW-1:0] end_addr,
  input  logic          clr,
  output logic          flag_n
);
  logic hit;

  assign hit = inc_take && (ptr_inc == end_addr);

  // Set wins over clear on the same edge.
  always_ff @(posedge clk) begin
    if (rst)      flag_n <= 1'b1;
    else if (hit) flag_n <= 1'b0;
    else if (clr) flag_n <= 1'b1;
  end
endmodule

// File: rtl/seq_addr_ptr.sv
module seq_addr_ptr #(
  parameter int unsigned AW    = seq_ptr_pkg::PTR_W,
  parameter int unsigned LW    = seq_ptr_pkg::LOAD_W,
  parameter int unsigned IDX_W = seq_ptr_pkg::IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en_n,
  input  logic             ld_n,
  input  logic             strt1_n,
  input  logic             strt2_n,
  input  logic [LW-1:0]    din,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [AW-1:0]    cfg_data,
  input  logic             ctl_we,
  input  logic [1:0]       ctl_data,
  output logic [AW-1:0]    ptr,
  output logic             eob1_n,
  output logic             eob2_n
);
  localparam int unsigned NBUF = 2;

  logic [NBUF-1:0][AW-1:0] start_addr;
  logic [NBUF-1:0][AW-1:0] end_addr;
  logic [NBUF-1:0]         strt_n;
  logic [NBUF-1:0]         eob_n;
  logic [AW-1:0]           ptr_inc;
  logic                    inc_take;
  logic                    ld_pend;

  assign strt_n = {strt2_n, strt1_n};
  assign eob1_n = eob_n[0];
  assign eob2_n = eob_n[1];

  seq_ptr_regs #(.AW(AW), .NBUF(NBUF), .IDX_W(IDX_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_idx    (cfg_idx),
    .cfg_data   (cfg_data),
    .start_addr (start_addr),
    .end_addr   (end_addr)
  );

  seq_ptr_core #(.AW(AW), .LW(LW), .NBUF(NBUF)) u_core (
    .clk        (clk),
    .rst        (rst),
    .cnt_en_n   (cnt_en_n),
    .ld_n       (ld_n),
    .strt_n     (strt_n),
    .din        (din),
    .start_addr (start_addr),
    .ptr        (ptr),
    .ptr_inc    (ptr_inc),
    .inc_take   (inc_take),
    .ld_pend    (ld_pend)
  );

  for (genvar b = 0; b < NBUF; b++) begin : g_flag
    seq_ptr_flag #(.AW(AW)) u_flag (
      .clk      (clk),
      .rst      (rst),
      .inc_take (inc_take),
      .ptr_inc  (ptr_inc),
      .end_addr (end_addr[b]),
      .clr      (ctl_we && !ctl_data[b]),
      .flag_n   (eob_n[b])
    );
  end
endmodule

// File: rtl/seq_addr_ptr_chk.sv
module seq_addr_ptr_chk #(
  parameter int unsigned AW = seq_ptr_pkg::PTR_W,
  parameter int unsigned LW = seq_ptr_pkg::LOAD_W
) (
  input logic          clk,
  input logic          rst,
  input logic          cnt_en_n,
  input logic          ld_n,
  input logic          strt1_n,
  input logic          strt2_n,
  input logic [LW-1:0] din,
  input logic          ctl_we,
  input logic [1:0]    ctl_data,
  input logic [AW-1:0] ptr,
  input logic          eob1_n,
  input logic          eob2_n,
  input logic          ld_pend
);
  logic was_rst = 1'b0;

  always @(posedge clk) begin
    // R1
    if (was_rst) begin
      rst_state_chk: assert (ptr == '0 && eob1_n && eob2_n);
    end
    was_rst <= rst;
  end

  // R2
  incr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_pend && strt1_n && strt2_n && !cnt_en_n) |=> ptr == $past(ptr) + 1'b1);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_pend && strt1_n && strt2_n && cnt_en_n) |=> $stable(ptr));

  // R3
  load_delay_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_n |=> ##1 ptr == AW'($past(din, 2)));

  // R4
  strobe_rule_chk: assert property (@(posedge clk) disable iff (rst)
    (!strt1_n || !strt2_n) |-> (ld_n && !ld_pend));

  // R7
  flag1_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(eob1_n) |-> $past(!cnt_en_n));

  // R7
  flag2_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(eob2_n) |-> $past(!cnt_en_n));

  // R8
  flag1_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!eob1_n && !(ctl_we && !ctl_data[0])) |=> !eob1_n);

  // R8
  flag2_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!eob2_n && !(ctl_we && !ctl_data[1])) |=> !eob2_n);

  // R8
  flag1_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && !ctl_data[0] && cnt_en_n && !ld_pend) |=> eob1_n);
endmodule

bind seq_addr_ptr seq_addr_ptr_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cnt_en_n (cnt_en_n),
  .ld_n     (ld_n),
  .strt1_n  (strt1_n),
  .strt2_n  (strt2_n),
  .din      (din),
  .ctl_we   (ctl_we),
  .ctl_data (ctl_data),
  .ptr      (ptr),
  .eob1_n   (eob1_n),
  .eob2_n   (eob2_n),
  .ld_pend  (ld_pend)
);

// File: tb/seq_addr_ptr_tb.sv
module seq_addr_ptr_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en_n = 1'b1;
  logic        ld_n = 1'b1;
  logic        strt1_n = 1'b1;
  logic        strt2_n = 1'b1;
  logic [11:0] din = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [12:0] cfg_data = '0;
  logic        ctl_we = 1'b0;
  logic [1:0]  ctl_data = 2'b11;
  logic [12:0] ptr;
  logic        eob1_n;
  logic        eob2_n;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  // behavioural reference state
  int m_ptr, m_dreg, m_s1, m_e1, m_s2, m_e2, m_nptr;
  bit m_pend, m_f1, m_f2, m_inc;

  always #5 clk = ~clk;

  seq_addr_ptr u_dut (
    .clk(clk), .rst(rst), .cnt_en_n(cnt_en_n), .ld_n(ld_n),
    .strt1_n(strt1_n), .strt2_n(strt2_n), .din(din),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .ctl_we(ctl_we), .ctl_data(ctl_data),
    .ptr(ptr), .eob1_n(eob1_n), .eob2_n(eob2_n)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_ptr = 0; m_pend = 0; m_dreg = 0;
      m_s1 = 0; m_e1 = 0; m_s2 = 0; m_e2 = 0;
      m_f1 = 1; m_f2 = 1;
    end else begin
      m_inc = 0;
      if (m_pend) m_nptr = m_dreg;
      else if (!strt1_n) m_nptr = m_s1;
      else if (!strt2_n) m_nptr = m_s2;
      else if (!cnt_en_n) begin m_nptr = (m_ptr + 1) % 8192; m_inc = 1; end
      else m_nptr = m_ptr;
      if (ctl_we && !ctl_data[0]) m_f1 = 1;
      if (ctl_we && !ctl_data[1]) m_f2 = 1;
      if (m_inc && m_nptr == m_e1) m_f1 = 0;
      if (m_inc && m_nptr == m_e2) m_f2 = 0;
      if (cfg_we) begin
        case (cfg_idx)
          3'd0: m_s1 = int'(cfg_data);
          3'd1: m_e1 = int'(cfg_data);
          3'd2: m_s2 = int'(cfg_data);
          3'd3: m_e2 = int'(cfg_data);
          default: ;
        endcase
      end
      m_pend = !ld_n;
      if (!ld_n) m_dreg = int'(din);
      m_ptr = m_nptr;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock: drive already set, compare model and DUT after the edge
  task automatic tick();
    @(posedge clk);
    #1;
    chk(phase, "ptr", int'(ptr), m_ptr);
    chk(phase, "eob1_n", int'(eob1_n), int'(m_f1));
    chk(phase, "eob2_n", int'(eob2_n), int'(m_f2));
    @(negedge clk);
    cnt_en_n = 1; ld_n = 1; strt1_n = 1; strt2_n = 1;
    cfg_we = 0; ctl_we = 0; ctl_data = 2'b11;
  endtask

  task automatic cfg(input int idx, input int val);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_data = 13'(val);
    tick();
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    rst = 0;
    phase = "R1";
    chk("R1", "reset ptr", int'(ptr), 0);
    chk("R1", "reset eob1_n", int'(eob1_n), 1);
    chk("R1", "reset eob2_n", int'(eob2_n), 1);

    phase = "R6";
    cfg(0, 100); cfg(1, 105); cfg(2, 8190); cfg(3, 3);
    cfg(6, 777); cfg(5, 50);   // ignored indices

    phase = "R4";
    strt1_n = 0; tick();
    chk("R4", "strobe1 jump, R6 index 6 ignored", int'(ptr), 100);

    phase = "R7";
    for (int i = 0; i < 4; i++) begin cnt_en_n = 0; tick(); end
    chk("R7", "flag1 before end", int'(eob1_n), 1);
    cnt_en_n = 0; tick();
    chk("R7", "flag1 at end", int'(eob1_n), 0);
    chk("R2", "count value", int'(ptr), 105);

    phase = "R8";
    repeat (3) begin cnt_en_n = 0; tick(); end
    chk("R8", "flag1 sticky", int'(eob1_n), 0);
    ctl_we = 1; ctl_data = 2'b01; tick();
    chk("R8", "bit 1 set leaves flag1", int'(eob1_n), 0);
    ctl_we = 1; ctl_data = 2'b10; tick();
    chk("R8", "flag1 cleared", int'(eob1_n), 1);

    phase = "R2";
    strt2_n = 0; tick();
    chk("R4", "strobe2 jump", int'(ptr), 8190);
    cnt_en_n = 0; tick();
    cnt_en_n = 0; tick();
    chk("R2", "wrap to zero", int'(ptr), 0);
    tick();
    chk("R2", "hold without enable", int'(ptr), 0);
    phase = "R7";
    repeat (3) begin cnt_en_n = 0; tick(); end
    chk("R7", "flag2 at end", int'(eob2_n), 0);
    chk("R7", "flag1 untouched", int'(eob1_n), 1);

    phase = "R5";
    strt1_n = 0; strt2_n = 0; cnt_en_n = 0; tick();
    chk("R5", "strobe1 over strobe2 and count", int'(ptr), 100);

    phase = "R3";
    ld_n = 0; din = 12'hABC; cnt_en_n = 0; tick();
    chk("R3", "count on capture edge", int'(ptr), 101);
    cnt_en_n = 0; tick();
    chk("R3", "load applied over count", int'(ptr), 12'hABC);

    phase = "R7";
    ld_n = 0; din = 12'd105; tick();
    tick();
    chk("R7", "load onto end leaves flag1", int'(eob1_n), 1);
    strt1_n = 0; tick();
    cnt_en_n = 0; tick();
    cnt_en_n = 0; tick();
    cnt_en_n = 0; tick();
    cnt_en_n = 0; tick();
    chk("R8", "ptr at 104", int'(ptr), 104);
    phase = "R8";
    cnt_en_n = 0; ctl_we = 1; ctl_data = 2'b00; tick();
    chk("R8", "set beats clear", int'(eob1_n), 0);
    chk("R8", "flag2 cleared", int'(eob2_n), 1);

    phase = "R6";
    ctl_we = 1; ctl_data = 2'b10; tick();
    strt1_n = 0; tick();
    cnt_en_n = 0; cfg_we = 1; cfg_idx = 3'd1; cfg_data = 13'd102; tick();
    chk("R6", "old end used on write edge", int'(eob1_n), 1);
    cnt_en_n = 0; tick();
    chk("R6", "new end used next edge", int'(eob1_n), 0);

    phase = "R1";
    ld_n = 0; din = 12'h123; tick();
    rst = 1; tick();
    rst = 0;
    chk("R1", "ptr after reset", int'(ptr), 0);
    chk("R1", "flag1 after reset", int'(eob1_n), 1);
    tick();
    chk("R1", "pending load cancelled", int'(ptr), 0);
    strt1_n = 0; tick();
    chk("R1", "start1 reset to zero", int'(ptr), 0);
    cnt_en_n = 0; tick();
    chk("R1", "end1 reset to zero, no flag", int'(eob1_n), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule